// File: doc/BRIEF.md
# Crossbar Slave-Port Priority Arbiter

This block sits in front of every slave port of a bus crossbar and decides which of up to six masters drives each slave. Every master presents a request, a slave index, a 32-bit address, write data, a write flag and an end-of-transfer flag. Each slave port has its own arbiter, so masters aimed at different slaves are granted in the same cycle and never hold each other up. The winner's address, write data and write flag are steered to the slave. Each master gets back the read data of the slave it addresses and an acknowledge when its beat is taken.

When several masters want the same slave, a 3-bit priority level per master, supplied by software through `prio_cfg`, decides. A parameter selects which masters may use a sideband boost. By default these are master 2 (the DMA engine) and master 5 (the I/O processor). While a capable master holds its boost input high, it outranks every master that is not boosted.

A transfer may last several beats. The slave stays with its owner until the final beat is accepted. After that, arbitration happens again in the very next cycle with no idle beat. The last owner keeps the slave whenever no other requester outranks it.

Top module: `xbar_port_arbiter`

## Requirements
- R1: `m_tgt` is a 2-bit slave index per master, in bits [2i+1:2i] for master i. Each slave's grant in `s_gnt` (bits [6j+5:6j] for slave j, bit i for master i) is zero or one-hot. A new grant goes only to a master requesting that slave. A master whose index is 3 or more (no such slave) is never granted.
- R2: Masters that request different slaves are all granted in the same cycle, combinationally from the inputs.
- R3: Among contending masters with no boost, the one with the largest 3-bit level wins. The level for master i is in `prio_cfg` bits [3i+2:3i].
- R4: When effective priorities are equal, the lowest-numbered master wins, unless the tie includes the slave's last owner (R8).
- R5: A boost request on `elev_req[i]` counts only for masters set in `ELEV_MASK` (default masters 2 and 5) and is ignored for the others. A boosted master outranks every master that is not boosted. Among boosted masters, the level and then the index decide.
- R6: Once a master drops its boost, it competes at its ordinary level from the next arbitration on, even if it was the last owner.
- R7: After a beat with `m_last` low is accepted, the grant stays with that master until a beat with `m_last` high is accepted, whatever other masters request.
- R8: Back-to-back transfers need no gap: arbitration runs in the cycle right after a final beat. The last owner wins ties at its own effective priority.
- R9: `s_addr`, `s_wdata` and `s_wr` of a slave carry the granted master's values. `m_rdata` of a master carries `s_rdata` of its targeted slave. `m_ack[i]` is high when master i is granted and that slave's `s_ready` is high.
- R10: After reset with no requests, `s_gnt`, `s_valid` and `m_ack` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| m_req | input | 6 | Per-master request |
| m_tgt | input | 12 | Per-master slave index, 2 bits each |
| m_wr | input | 6 | Per-master write flag |
| m_last | input | 6 | Per-master final-beat flag |
| m_addr | input | 192 | Per-master address, 32 bits each |
| m_wdata | input | 192 | Per-master write data, 32 bits each |
| m_rdata | output | 192 | Per-master read data, 32 bits each |
| m_ack | output | 6 | Per-master beat accepted |
| prio_cfg | input | 18 | Per-master priority level, 3 bits each |
| elev_req | input | 6 | Per-master priority boost request |
| s_gnt | output | 18 | Per-slave one-hot grant, 6 bits each |
| s_valid | output | 3 | Per-slave beat valid |
| s_wr | output | 3 | Per-slave write flag |
| s_addr | output | 96 | Per-slave address, 32 bits each |
| s_wdata | output | 96 | Per-slave write data, 32 bits each |
| s_rdata | input | 96 | Per-slave read data, 32 bits each |
| s_ready | input | 3 | Per-slave beat accepted |

## Verification
Some properties are checked on every cycle. Each slave's grant is zero or one-hot and goes to a requester when the slave is free. The grant is frozen across a multi-beat transfer. A boosted requester always wins a free slave. A slave whose final beat was just taken is driven again at once when anyone requests it. Other behaviour depends on chosen inputs, and only the bench scenarios show it: the exact winner for given level settings, the lowest-index tie rule, the boost being ignored on masters not allowed to use it, ownership kept on a tie but lost to a higher level, and the steering of address, data and read data.

// File: rtl/xbar_arb_pkg.sv
package xbar_arb_pkg;

    localparam int XA_AW = 32;
    localparam int XA_DW = 32;
    localparam int XA_PW = 3;

    // Effective rank: boost bit on top of the programmed level.
    typedef logic [XA_PW:0] rank_t;

    typedef struct packed {
        logic              wr;
        logic              last;
        logic [XA_AW-1:0]  addr;
        logic [XA_DW-1:0]  data;
    } beat_t;

    function automatic rank_t make_rank(input logic boost, input logic [XA_PW-1:0] lvl);
        return {boost, lvl};
    endfunction

    function automatic logic outranks(input rank_t a, input rank_t b);
        return a > b;
    endfunction

endpackage

// File: rtl/xarb_pick.sv
module xarb_pick
    import xbar_arb_pkg::*;
#(
    parameter int NM = 6,
    parameter int IW = (NM > 1) ? $clog2(NM) : 1
) (
    input  logic [NM-1:0] req,
    input  rank_t         rank [NM],
    input  logic          hold_ok,
    input  logic [IW-1:0] hold_idx,
    output logic [IW-1:0] win_idx,
    output logic          win_any
);

    rank_t best;

    always_comb begin
        best    = '0;
        win_idx = '0;
        win_any = 1'b0;
        // strict compare keeps the lowest index on equal rank
        for (int i = 0; i < NM; i++) begin
            if (req[i] && (!win_any || outranks(rank[i], best))) begin
                win_any = 1'b1;
                best    = rank[i];
                win_idx = IW'(i);
            end
        end
        // last owner keeps the slave when it ties the best rank
        if (win_any && hold_ok && req[hold_idx] && (rank[hold_idx] == best))
            win_idx = hold_idx;
    end

endmodule

// File: rtl/xarb_lane.sv
module xarb_lane
    import xbar_arb_pkg::*;
#(
    parameter int NM = 6,
    parameter int IW = (NM > 1) ? $clog2(NM) : 1
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [NM-1:0] req,
    input  logic [NM-1:0] boost,
    input  rank_t         rank [NM],
    input  beat_t         beat [NM],
    input  logic          s_ready,
    output logic [NM-1:0] gnt,
    output logic          s_valid,
    output beat_t         s_beat
);

    logic          busy;
    logic          parked;
    logic [IW-1:0] owner;
    logic [IW-1:0] pick_idx;
    logic          pick_any;
    logic [IW-1:0] sel_idx;
    logic          accept;

    xarb_pick #(.NM(NM), .IW(IW)) u_pick (
        .req      (req),
        .rank     (rank),
        .hold_ok  (parked),
        .hold_idx (owner),
        .win_idx  (pick_idx),
        .win_any  (pick_any)
    );

    always_comb begin
        sel_idx = busy ? owner : pick_idx;
        s_valid = busy ? req[owner] : pick_any;
        gnt     = '0;
        if (busy || pick_any)
            gnt[sel_idx] = 1'b1;
        s_beat  = s_valid ? beat[sel_idx] : '0;
        accept  = s_valid && s_ready;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            busy   <= 1'b0;
            parked <= 1'b0;
            owner  <= '0;
        end else if (accept) begin
            owner  <= sel_idx;
            parked <= 1'b1;
            busy   <= !s_beat.last;
        end
    end

    assert_gnt_onehot_R1: assert property (@(posedge clk) disable iff (rst)
        $onehot0(gnt));

    assert_gnt_to_req_R1: assert property (@(posedge clk) disable iff (rst)
        !busy |-> ((gnt & ~req) == '0));

    assert_hold_R7: assert property (@(posedge clk) disable iff (rst)
        (accept && !s_beat.last) |=> (gnt == $past(gnt)));

    assert_boost_wins_R5: assert property (@(posedge clk) disable iff (rst)
        (!busy && ((req & boost) != '0)) |-> ((gnt & boost) != '0));

    assert_no_gap_R8: assert property (@(posedge clk) disable iff (rst)
        (accept && s_beat.last) |=> ((req == '0) || s_valid));

endmodule

// File: rtl/xbar_port_arbiter.sv
module xbar_port_arbiter
    import xbar_arb_pkg::*;
#(
    parameter int                NUM_M     = 6,
    parameter int                NUM_S     = 3,
    parameter logic [NUM_M-1:0]  ELEV_MASK = 6'b100100,
    localparam int               SW        = (NUM_S > 1) ? $clog2(NUM_S) : 1,
    localparam int               IW        = (NUM_M > 1) ? $clog2(NUM_M) : 1
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic [NUM_M-1:0]         m_req,
    input  logic [NUM_M*SW-1:0]      m_tgt,
    input  logic [NUM_M-1:0]         m_wr,
    input  logic [NUM_M-1:0]         m_last,
    input  logic [NUM_M*XA_AW-1:0]   m_addr,
    input  logic [NUM_M*XA_DW-1:0]   m_wdata,
    output logic [NUM_M*XA_DW-1:0]   m_rdata,
    output logic [NUM_M-1:0]         m_ack,
    input  logic [NUM_M*XA_PW-1:0]   prio_cfg,
    input  logic [NUM_M-1:0]         elev_req,
    output logic [NUM_S*NUM_M-1:0]   s_gnt,
    output logic [NUM_S-1:0]         s_valid,
    output logic [NUM_S-1:0]         s_wr,
    output logic [NUM_S*XA_AW-1:0]   s_addr,
    output logic [NUM_S*XA_DW-1:0]   s_wdata,
    input  logic [NUM_S*XA_DW-1:0]   s_rdata,
    input  logic [NUM_S-1:0]         s_ready
);

    beat_t            beat    [NUM_M];
    rank_t            rank    [NUM_M];
    logic [NUM_M-1:0] boost;
    logic [NUM_M-1:0] req_to  [NUM_S];
    logic [NUM_M-1:0] gnt_to  [NUM_S];
    beat_t            lane_bt [NUM_S];

    for (genvar i = 0; i < NUM_M; i++) begin : g_master
        assign boost[i] = elev_req[i] & ELEV_MASK[i];
        assign rank[i]  = make_rank(boost[i], prio_cfg[i*XA_PW +: XA_PW]);
        assign beat[i]  = '{wr:   m_wr[i],
                            last: m_last[i],
                            addr: m_addr[i*XA_AW +: XA_AW],
                            data: m_wdata[i*XA_DW +: XA_DW]};
    end

    always_comb begin
        for (int j = 0; j < NUM_S; j++)
            for (int i = 0; i < NUM_M; i++)
                req_to[j][i] = m_req[i] && (m_tgt[i*SW +: SW] == SW'(j));
    end

    for (genvar j = 0; j < NUM_S; j++) begin : g_slave
        xarb_lane #(.NM(NUM_M), .IW(IW)) u_lane (
            .clk     (clk),
            .rst     (rst),
            .req     (req_to[j]),
            .boost   (boost),
            .rank    (rank),
            .beat    (beat),
            .s_ready (s_ready[j]),
            .gnt     (gnt_to[j]),
            .s_valid (s_valid[j]),
            .s_beat  (lane_bt[j])
        );
        assign s_gnt[j*NUM_M +: NUM_M]   = gnt_to[j];
        assign s_wr[j]                   = lane_bt[j].wr;
        assign s_addr[j*XA_AW +: XA_AW]  = lane_bt[j].addr;
        assign s_wdata[j*XA_DW +: XA_DW] = lane_bt[j].data;
    end

    // return path: acknowledge and read data back to each master
    always_comb begin
        m_ack   = '0;
        m_rdata = '0;
        for (int i = 0; i < NUM_M; i++) begin
            for (int j = 0; j < NUM_S; j++) begin
                if (m_req[i] && gnt_to[j][i] && s_ready[j])
                    m_ack[i] = 1'b1;
                if (m_tgt[i*SW +: SW] == SW'(j))
                    m_rdata[i*XA_DW +: XA_DW] = s_rdata[j*XA_DW +: XA_DW];
            end
        end
    end

    assert_ack_needs_ready_R9: assert property (@(posedge clk) disable iff (rst)
        (m_ack != '0) |-> (s_ready != '0));

    assert_ack_single_slave_R2: assert property (@(posedge clk) disable iff (rst)
        $countones(m_ack) <= $countones(s_ready));

endmodule

// File: tb/xbar_port_arbiter_test.sv
module xbar_port_arbiter_test;

    localparam int CLK_PERIOD = 10;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #(CLK_PERIOD/2) clk = ~clk;

    logic [5:0]  req, last, wr, elev;
    logic [1:0]  tgt   [6];
    logic [2:0]  prio  [6];
    logic [31:0] addr  [6];
    logic [31:0] wd    [6];
    logic [2:0]  rdy;
    logic [31:0] rd    [3];

    logic [11:0]  m_tgt;
    logic [191:0] m_addr, m_wdata, m_rdata;
    logic [17:0]  prio_cfg;
    logic [5:0]   m_ack;
    logic [17:0]  s_gnt;
    logic [2:0]   s_valid, s_wr;
    logic [95:0]  s_addr, s_wdata, s_rdata;

    for (genvar i = 0; i < 6; i++) begin : g_m
        assign m_tgt[2*i +: 2]     = tgt[i];
        assign prio_cfg[3*i +: 3]  = prio[i];
        assign m_addr[32*i +: 32]  = addr[i];
        assign m_wdata[32*i +: 32] = wd[i];
    end
    for (genvar j = 0; j < 3; j++) begin : g_s
        assign s_rdata[32*j +: 32] = rd[j];
    end

    xbar_port_arbiter uut (
        .clk(clk), .rst(rst), .m_req(req), .m_tgt(m_tgt), .m_wr(wr),
        .m_last(last), .m_addr(m_addr), .m_wdata(m_wdata), .m_rdata(m_rdata),
        .m_ack(m_ack), .prio_cfg(prio_cfg), .elev_req(elev), .s_gnt(s_gnt),
        .s_valid(s_valid), .s_wr(s_wr), .s_addr(s_addr), .s_wdata(s_wdata),
        .s_rdata(s_rdata), .s_ready(rdy)
    );

    int total = 0;
    int fails = 0;
    bit done  = 0;

    task automatic chk(input string rq, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: got %h expected %h", rq, what, act, exp);
        end
    endtask

    typedef struct packed {
        logic [3:0]  rq;
        logic [5:0]  req;
        logic [11:0] tgt;
        logic [17:0] prio;
        logic [5:0]  elev;
        logic [17:0] gnt;
    } vec_t;

    localparam int NV = 11;
    localparam vec_t TBL [NV] = '{
        '{4'd1, 6'b000001, 12'h000, 18'o000000, 6'b000000, 18'b000000_000000_000001}, // R1 lone request
        '{4'd2, 6'b000111, 12'b000000100100, 18'o000000, 6'b000000, 18'b000100_000010_000001}, // R2 parallel
        '{4'd3, 6'b111111, 12'h555, 18'o543210, 6'b000000, 18'b000000_100000_000000}, // R3 highest level
        '{4'd4, 6'b111111, 12'haaa, 18'o007172, 6'b000000, 18'b000010_000000_000000}, // R4 tie at level 7
        '{4'd4, 6'b111100, 12'h000, 18'o000000, 6'b000000, 18'b000000_000000_000100}, // R4 uniform levels
        '{4'd5, 6'b111111, 12'h000, 18'o543210, 6'b000100, 18'b000000_000000_000100}, // R5 boost m2
        '{4'd5, 6'b111111, 12'h000, 18'o543210, 6'b000011, 18'b000000_000000_100000}, // R5 boost ignored
        '{4'd5, 6'b111111, 12'h000, 18'o000000, 6'b100100, 18'b000000_000000_000100}, // R5 boosted tie
        '{4'd5, 6'b111111, 12'h000, 18'o543210, 6'b100100, 18'b000000_000000_100000}, // R5 boosted by level
        '{4'd1, 6'b000011, 12'b000000001111, 18'o000000, 6'b000000, 18'b0},           // R1 no such slave
        '{4'd3, 6'b001111, 12'b000010100000, 18'o001431, 6'b000000, 18'b000100_000000_000010}  // R3 two slaves
    };

    task automatic clear_inputs();
        req = '0; last = '1; wr = '0; elev = '0; rdy = '0;
        for (int i = 0; i < 6; i++) begin
            tgt[i]  = 2'd0;
            prio[i] = 3'd0;
            addr[i] = 32'h4000_0000 + 32'(i) * 32'h100;
            wd[i]   = 32'hD000_0000 + 32'(i);
        end
        for (int j = 0; j < 3; j++) rd[j] = 32'hAB00_0000 + 32'(j);
    endtask

    function automatic logic [2:0] valid_of(input logic [17:0] g);
        return {|g[17:12], |g[11:6], |g[5:0]};
    endfunction

    initial begin
        clear_inputs();
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        #2;
        // R10 reset state
        chk("R10", "s_gnt", 64'(s_gnt), 64'd0);
        chk("R10", "s_valid", 64'(s_valid), 64'd0);
        chk("R10", "m_ack", 64'(m_ack), 64'd0);

        // table walk: ready low, so no state changes
        for (int v = 0; v < NV; v++) begin
            @(negedge clk);
            clear_inputs();
            req  = TBL[v].req;
            elev = TBL[v].elev;
            for (int i = 0; i < 6; i++) begin
                tgt[i]  = TBL[v].tgt[2*i +: 2];
                prio[i] = TBL[v].prio[3*i +: 3];
            end
            #2;
            chk($sformatf("R%0d", TBL[v].rq), $sformatf("vec%0d s_gnt", v),
                64'(s_gnt), 64'(TBL[v].gnt));
            chk($sformatf("R%0d", TBL[v].rq), $sformatf("vec%0d s_valid", v),
                64'(s_valid), 64'(valid_of(TBL[v].gnt)));
        end

        // R7 hold across a two-beat transfer on slave 1
        @(negedge clk); clear_inputs();
        req[3] = 1; tgt[3] = 2'd1; last[3] = 0; rdy[1] = 1;
        #2;
        chk("R7", "first beat grant", 64'(s_gnt[11:6]), 64'b001000);
        chk("R9", "first beat ack", 64'(m_ack), 64'b001000);
        @(negedge clk);
        last[3] = 1;
        req[0] = 1; tgt[0] = 2'd1; prio[0] = 3'd7;
        req[2] = 1; tgt[2] = 2'd1; elev[2] = 1;
        #2;
        chk("R7", "held grant", 64'(s_gnt[11:6]), 64'b001000);
        @(negedge clk);
        #2;
        // R8 no idle cycle; R5 boosted m2 takes over
        chk("R8", "regrant no gap", 64'(s_gnt[11:6]), 64'b000100);
        chk("R8", "valid no gap", 64'(s_valid[1]), 64'd1);
        @(negedge clk);
        req[2] = 0; elev[2] = 0;
        #2;
        chk("R3", "level 7 beats level 0", 64'(s_gnt[11:6]), 64'b000001);

        // R8 owner keeps slave on a tie
        @(negedge clk); clear_inputs();
        req[4] = 1; tgt[4] = 2'd2; rdy[2] = 1;
        #2;
        chk("R8", "sole request", 64'(s_gnt[17:12]), 64'b010000);
        @(negedge clk);
        req[1] = 1; tgt[1] = 2'd2;
        #2;
        chk("R8", "owner wins tie", 64'(s_gnt[17:12]), 64'b010000);
        @(negedge clk);
        req[4] = 0; req[2] = 1; tgt[2] = 2'd2;
        #2;
        chk("R4", "lowest index after owner leaves", 64'(s_gnt[17:12]), 64'b000010);

        // R6 boost dropped: ordinary level applies again
        @(negedge clk); clear_inputs();
        req[5] = 1; elev[5] = 1; req[0] = 1; prio[0] = 3'd3; rdy[0] = 1;
        #2;
        chk("R5", "boosted m5 over level 3", 64'(s_gnt[5:0]), 64'b100000);
        @(negedge clk);
        elev[5] = 0;
        #2;
        chk("R6", "unboosted owner loses", 64'(s_gnt[5:0]), 64'b000001);

        // R9 datapath steering
        @(negedge clk); clear_inputs();
        req[1] = 1; tgt[1] = 2'd0; wr[1] = 1;
        addr[1] = 32'hA1A1_0040; wd[1] = 32'h1234_5678;
        req[4] = 1; tgt[4] = 2'd2; addr[4] = 32'hB4B4_0080;
        rd[0] = 32'hCAFE_0000; rd[2] = 32'hBEEF_0002; rdy[0] = 1;
        #2;
        chk("R9", "s_addr0", 64'(s_addr[31:0]), 64'h0000_0000_A1A1_0040);
        chk("R9", "s_wdata0", 64'(s_wdata[31:0]), 64'h0000_0000_1234_5678);
        chk("R9", "s_wr", 64'(s_wr), 64'b001);
        chk("R9", "s_addr2", 64'(s_addr[95:64]), 64'h0000_0000_B4B4_0080);
        chk("R9", "m_rdata1", 64'(m_rdata[63:32]), 64'h0000_0000_CAFE_0000);
        chk("R9", "m_rdata4", 64'(m_rdata[159:128]), 64'h0000_0000_BEEF_0002);
        chk("R9", "m_ack", 64'(m_ack), 64'b000010);

        @(negedge clk); clear_inputs();
        #2;
        chk("R10", "idle after traffic", 64'(s_valid), 64'd0);

        done = 1;
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            total++;
            fails++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("%0d/%0d checks passed", total - fails, total);
            $finish;
        end
    end

endmodule